// File: doc/BRIEF.md
# Timer capture/compare pin unit

This peripheral couples one general-purpose pin to an externally supplied free-running timer count. Software programs a control register, a 16-bit compare register and a write-one-to-clear status register through a small register port. A two-bit mode field selects one of three behaviours: a timing mode, a timer-interrupt mode and a standard mode.

In timing mode with the pin set as an input, the unit timestamps the moment the synchronized pin reaches a chosen level. The timestamp goes into the compare register. A compare match that happens first is recorded as a timeout, and separate flags tell the two outcomes apart. In timing mode with the pin set as an output, every compare match flips an internal latch, and the pin shows that latch combined with the polarity bit. Software builds an arbitrary waveform by reloading the compare value after each match. In timer-interrupt mode a compare match raises the interrupt even when the pin interrupt is masked, and the pin stays in its plain role.

Top module: `tcc_pin_unit`

## Requirements
- R1: After reset the control, compare and status registers read 0, and `pin_out`, `pin_oe` and `irq` are low.
- R2: Register map by `reg_addr`, with combinational reads:
   - 0 is control: bits 13:12 mode, bit 8 interrupt mask (1 = masked), bit 1 direction (1 = output), bit 0 polarity. All other bits read 0.
   - 1 is the 16-bit compare value.
   - 2 is status: bit 8 event flag, bit 7 equal flag, bit 0 synchronized pin level.
   - 3 reads 0.
- R3: In timing mode (mode 2'b01) with direction input, the synchronized pin is compared with polarity. The pin passes two flip-flops, so a change on `pin_in` is seen at the third clock edge. When the event flag is clear and the levels match, that edge sets the event flag and loads timer bits 15..0 into the compare register. While the event flag stays set, the compare register is not overwritten.
- R4: In timing mode with direction input, a compare match sets the equal flag only while the event flag is clear (a timeout). The event flag may still be set after the equal flag. Once the event flag is set, later matches leave the equal flag clear.
- R5: If the pin is already at the polarity level when timing mode is entered, the event flag is set on the next clock edge.
- R6: A match occurs only on the clock edge at which `timer_cnt` differs from its value at the previous edge and its bits 15..0 equal the compare value. The upper timer bits do not take part in the comparison. A timer that holds still never matches again.
- R7: In timing mode with direction output, each match sets the equal flag and flips the toggle latch. `pin_out` is the latch XOR polarity.
- R8: A control write with bit 13 = 1 clears the toggle latch. Such a write that also inverts polarity leaves `pin_out` unchanged.
- R9: In timing mode, `irq` = (event flag OR equal flag) AND NOT mask.
- R10: In timer-interrupt mode (mode 2'b00), a match sets the equal flag and `irq` follows the equal flag whatever the mask is. The event flag is never set, and `pin_out` equals polarity.
- R11: In standard mode (bit 13 = 1), no flag is set, `irq` is low and `pin_out` equals polarity. In every mode `pin_oe` equals the direction bit.
- R12: Writing status clears each flag whose bit is written as 1. Bits written as 0 leave their flags alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rdata | output | DATA_W (16) | Read data for `reg_addr` |
| timer_cnt | input | TIMER_W (32) | Free-running timer count |
| pin_in | input | 1 | Pin level from the pad |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench counts the synchronizer latency edge by edge. A design with one stage too few or too many would report the event one cycle early or late. It holds the timer at a matching value for several cycles, so a comparator without change detection would keep flipping the pin. It triggers a timeout followed by a pin event, which catches a design that lets a match after the event overwrite the outcome or lets capture overwrite a recorded time. It also switches the latch clear and the polarity inversion together, and reads the flags around write-one-to-clear writes. A wrong clear priority or mask override would show up as a glitching pin, a stale interrupt or a lost flag.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
   typedef enum logic [1:0] {
      MODE_TMRINT = 2'b00,
      MODE_TIMING = 2'b01,
      MODE_STD_A  = 2'b10,
      MODE_STD_B  = 2'b11
   } tcc_mode_e;

   typedef struct packed {
      tcc_mode_e mode;
      logic      mask;
      logic      dir;
      logic      pol;
   } tcc_ctrl_t;

   localparam int unsigned BIT_MODE_HI = 13;
   localparam int unsigned BIT_MODE_LO = 12;
   localparam int unsigned BIT_MASK    = 8;
   localparam int unsigned BIT_DIR     = 1;
   localparam int unsigned BIT_POL     = 0;
   localparam int unsigned BIT_EVT     = 8;
   localparam int unsigned BIT_EQ      = 7;
   localparam int unsigned BIT_LVL     = 0;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_CMP  = 2'd1;
   localparam logic [1:0] ADDR_STS  = 2'd2;
endpackage

// File: rtl/tcc_sync.sv
module tcc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("tcc_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= 1'b0;
         else        r <= d;
      end
      assign q = r;
   end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= '0;
         else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
   end
endmodule

// File: rtl/tcc_match.sv
module tcc_match #(
   parameter int unsigned TIMER_W = 32,
   parameter int unsigned CMP_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TIMER_W-1:0] timer,
   input  logic [CMP_W-1:0]   cmp,
   output logic               match
);
   if (CMP_W > TIMER_W) begin : g_bad_width
      $error("tcc_match: CMP_W exceeds TIMER_W");
   end

   logic [TIMER_W-1:0] timer_q;
   logic               tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) timer_q <= '0;
      else        timer_q <= timer;
   end

   assign tick  = (timer != timer_q);
   assign match = tick && (timer[CMP_W-1:0] == cmp);
endmodule

// File: rtl/tcc_chan.sv
module tcc_chan
   import tcc_pkg::*;
#(
   parameter int unsigned CMP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tcc_mode_e        mode,
   input  logic             dir,
   input  logic             pol,
   input  logic             pin_lvl,
   input  logic             match,
   input  logic [CMP_W-1:0] timer_lo,
   input  logic             cmp_we,
   input  logic [CMP_W-1:0] cmp_wdata,
   input  logic             clr_evt,
   input  logic             clr_eq,
   input  logic             latch_clr,
   output logic [CMP_W-1:0] cmp_q,
   output logic             evt_q,
   output logic             eq_q,
   output logic             toggle_q
);
   logic timing_in, timing_out, tmrint;
   logic evt_set, eq_set;

   assign timing_in  = (mode == MODE_TIMING) && !dir;
   assign timing_out = (mode == MODE_TIMING) &&  dir;
   assign tmrint     = (mode == MODE_TMRINT);

   assign evt_set = timing_in && !evt_q && (pin_lvl == pol);
   assign eq_set  = match && ((timing_in && !evt_q && !evt_set) || timing_out || tmrint);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q    <= '0;
         evt_q    <= 1'b0;
         eq_q     <= 1'b0;
         toggle_q <= 1'b0;
      end else begin
         if (evt_set)     cmp_q <= timer_lo;
         else if (cmp_we) cmp_q <= cmp_wdata;

         if (evt_set)      evt_q <= 1'b1;
         else if (clr_evt) evt_q <= 1'b0;

         if (eq_set)      eq_q <= 1'b1;
         else if (clr_eq) eq_q <= 1'b0;

         if (latch_clr)                toggle_q <= 1'b0;
         else if (timing_out && match) toggle_q <= ~toggle_q;
      end
   end

   // R3: a level hit while waiting records the event and the timer value
   a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (timing_in && !evt_q && (pin_lvl == pol)) |=> (evt_q && cmp_q == $past(timer_lo)));

   // R4: no timeout is reported once the event is recorded
   a_r4_no_eq_after_evt: assert property (@(posedge clk) disable iff (!rst_n)
      (timing_in && evt_q && !eq_q) |=> !eq_q);

   // R7: a match in output timing mode flips the latch
   a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (timing_out && match && !latch_clr) |=> (toggle_q != $past(toggle_q)));

   // R8: the clearing write leaves the latch low
   a_r8_latch_clr: assert property (@(posedge clk) disable iff (!rst_n)
      latch_clr |=> !toggle_q);
endmodule

// File: rtl/tcc_pin_unit.sv
module tcc_pin_unit
   import tcc_pkg::*;
#(
   parameter int unsigned TIMER_W     = 32,
   parameter int unsigned CMP_W       = 16,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [1:0]         reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [TIMER_W-1:0] timer_cnt,
   input  logic               pin_in,
   output logic               pin_out,
   output logic               pin_oe,
   output logic               irq
);
   localparam int unsigned CTRL_TOP = BIT_MODE_HI + 1;

   if (DATA_W < CTRL_TOP) begin : g_bad_data
      $error("tcc_pin_unit: DATA_W too narrow for the control fields");
   end
   if (DATA_W < CMP_W) begin : g_bad_cmp
      $error("tcc_pin_unit: DATA_W narrower than CMP_W");
   end

   tcc_ctrl_t        ctrl_q;
   logic             ctrl_we, cmp_we, sts_we;
   logic             pin_lvl, match;
   logic [CMP_W-1:0] cmp_q;
   logic             evt_flag, eq_flag, toggle;

   assign ctrl_we = reg_we && (reg_addr == ADDR_CTRL);
   assign cmp_we  = reg_we && (reg_addr == ADDR_CMP);
   assign sts_we  = reg_we && (reg_addr == ADDR_STS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_we) begin
         ctrl_q.mode <= tcc_mode_e'(reg_wdata[BIT_MODE_HI:BIT_MODE_LO]);
         ctrl_q.mask <= reg_wdata[BIT_MASK];
         ctrl_q.dir  <= reg_wdata[BIT_DIR];
         ctrl_q.pol  <= reg_wdata[BIT_POL];
      end
   end

   tcc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_lvl)
   );

   tcc_match #(.TIMER_W(TIMER_W), .CMP_W(CMP_W)) u_match (
      .clk(clk), .rst_n(rst_n), .timer(timer_cnt), .cmp(cmp_q), .match(match)
   );

   tcc_chan #(.CMP_W(CMP_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (ctrl_q.mode),
      .dir       (ctrl_q.dir),
      .pol       (ctrl_q.pol),
      .pin_lvl   (pin_lvl),
      .match     (match),
      .timer_lo  (timer_cnt[CMP_W-1:0]),
      .cmp_we    (cmp_we),
      .cmp_wdata (reg_wdata[CMP_W-1:0]),
      .clr_evt   (sts_we && reg_wdata[BIT_EVT]),
      .clr_eq    (sts_we && reg_wdata[BIT_EQ]),
      .latch_clr (ctrl_we && reg_wdata[BIT_MODE_HI]),
      .cmp_q     (cmp_q),
      .evt_q     (evt_flag),
      .eq_q      (eq_flag),
      .toggle_q  (toggle)
   );

   assign pin_oe  = ctrl_q.dir;
   assign pin_out = (ctrl_q.mode == MODE_TIMING && ctrl_q.dir) ? (toggle ^ ctrl_q.pol) : ctrl_q.pol;

   always_comb begin
      unique case (ctrl_q.mode)
         MODE_TIMING: irq = (evt_flag || eq_flag) && !ctrl_q.mask;
         MODE_TMRINT: irq = eq_flag;
         default:     irq = 1'b0;
      endcase
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADDR_CTRL: begin
            reg_rdata[BIT_MODE_HI:BIT_MODE_LO] = ctrl_q.mode;
            reg_rdata[BIT_MASK]                = ctrl_q.mask;
            reg_rdata[BIT_DIR]                 = ctrl_q.dir;
            reg_rdata[BIT_POL]                 = ctrl_q.pol;
         end
         ADDR_CMP: reg_rdata[CMP_W-1:0] = cmp_q;
         ADDR_STS: begin
            reg_rdata[BIT_EVT] = evt_flag;
            reg_rdata[BIT_EQ]  = eq_flag;
            reg_rdata[BIT_LVL] = pin_lvl;
         end
         default: reg_rdata = '0;
      endcase
   end

   // R6: a timer that holds still cannot raise a new timeout/compare flag
   a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !sts_we && $stable(timer_cnt) && eq_flag == $past(eq_flag)) |=> $stable(eq_flag));

   // R10: timer-interrupt mode ignores the mask
   a_r10_mask_override: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.mode == MODE_TMRINT && eq_flag && ctrl_q.mask) |-> irq);

   // R11: standard mode never sets the equal flag
   a_r11_std_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.mode[1] && !eq_flag) |=> !eq_flag);

   // R9: masked timing mode keeps the interrupt low
   a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.mode == MODE_TIMING && ctrl_q.mask) |-> !irq);
endmodule

// File: tb/tcc_pin_unit_bench.sv
`timescale 1ns/1ps
module tcc_pin_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [31:0] timer_cnt = '0;
   logic        pin_in = 1'b0;
   logic        pin_out, pin_oe, irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tcc_pin_unit u_tcc_pin_unit (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timer_cnt(timer_cnt),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   // vector: {compare value, timer value, expected pin_out, expected equal flag}
   localparam logic [49:0] VEC [0:6] = '{
      {16'h0010, 32'h0000_0010, 1'b1, 1'b1},
      {16'h0020, 32'h0000_0015, 1'b1, 1'b0},
      {16'h0020, 32'h0000_0020, 1'b0, 1'b1},
      {16'h0030, 32'h0000_0030, 1'b1, 1'b1},
      {16'h0040, 32'h0000_0041, 1'b1, 1'b0},
      {16'hFFFF, 32'h0000_FFFF, 1'b0, 1'b1},
      {16'h0040, 32'h0001_0040, 1'b1, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic tset(input logic [31:0] v);
      @(negedge clk);
      timer_cnt = v;
      @(negedge clk);
   endtask

   initial begin : main
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 pin_out", pin_out, 0);
      chk("R1 pin_oe", pin_oe, 0);
      chk("R1 irq", irq, 0);
      rd(2'd0, d); chk("R1 ctrl", d, 0);
      rd(2'd1, d); chk("R1 cmp", d, 0);
      rd(2'd2, d); chk("R1 status", d, 0);

      // R2 / R11 register map and standard mode
      wr(2'd0, 16'hFFFF);
      rd(2'd0, d); chk("R2 ctrl readback", d, 16'h3103);
      chk("R11 std pin_out=pol", pin_out, 1);
      chk("R11 pin_oe=dir", pin_oe, 1);
      wr(2'd1, 16'h0042);
      rd(2'd1, d); chk("R2 cmp readback", d, 16'h0042);
      rd(2'd3, d); chk("R2 addr3 zero", d, 0);
      tset(32'h0000_0042);
      rd(2'd2, d); chk("R11 no flag in std", d, 0);
      chk("R11 irq low", irq, 0);

      // R7 / R6 output timing mode, vector walk
      wr(2'd0, 16'h1002);
      chk("R7 pin starts low", pin_out, 0);
      for (int i = 0; i < 7; i++) begin
         wr(2'd1, VEC[i][49:34]);
         tset(VEC[i][33:2]);
         chk($sformatf("R7 vec%0d pin_out", i), pin_out, VEC[i][1]);
         rd(2'd2, d);
         chk($sformatf("R6 vec%0d equal", i), d[7], VEC[i][0]);
         chk($sformatf("R9 vec%0d irq", i), irq, VEC[i][0]);
         wr(2'd2, 16'h0080);
      end

      // R6 held timer does not re-fire
      repeat (5) @(negedge clk);
      chk("R6 pin held", pin_out, 1);
      rd(2'd2, d); chk("R6 no refire", d, 0);

      // R8 latch clear with polarity inversion
      wr(2'd0, 16'h2103);
      chk("R8 no transition", pin_out, 1);
      wr(2'd0, 16'h1002);
      chk("R8 latch cleared", pin_out, 0);

      // R3 capture with synchronizer latency
      wr(2'd0, 16'h2100);
      wr(2'd2, 16'h0180);
      wr(2'd1, 16'h5555);
      tset(32'h0000_0777);
      wr(2'd0, 16'h1001);
      repeat (3) @(negedge clk);
      rd(2'd2, d); chk("R3 no event at wrong level", d, 0);
      pin_in = 1'b1;
      @(negedge clk); @(negedge clk);
      rd(2'd2, d); chk("R3 two-flop latency", d[8], 0);
      @(negedge clk);
      rd(2'd2, d); chk("R3 event status", d, 16'h0101);
      rd(2'd1, d); chk("R3 captured time", d, 16'h0777);
      chk("R9 irq on event", irq, 1);
      tset(32'h0000_0900);
      pin_in = 1'b0; repeat (4) @(negedge clk);
      pin_in = 1'b1; repeat (4) @(negedge clk);
      rd(2'd1, d); chk("R3 no overwrite", d, 16'h0777);

      // R9 mask
      wr(2'd0, 16'h1101);
      chk("R9 masked irq", irq, 0);
      wr(2'd0, 16'h1001);
      chk("R9 unmasked irq", irq, 1);

      // R4 timeout then event
      pin_in = 1'b0; repeat (3) @(negedge clk);
      wr(2'd2, 16'h0100);
      rd(2'd2, d); chk("R12 event cleared", d, 0);
      wr(2'd1, 16'h0A00);
      chk("R9 irq idle", irq, 0);
      tset(32'h0000_0A00);
      rd(2'd2, d); chk("R4 timeout flag", d, 16'h0080);
      chk("R9 irq on timeout", irq, 1);
      pin_in = 1'b1; repeat (4) @(negedge clk);
      rd(2'd2, d); chk("R4 event after timeout", d, 16'h0181);
      rd(2'd1, d); chk("R4 event time", d, 16'h0A00);
      wr(2'd2, 16'h0080);
      wr(2'd1, 16'h0B00);
      tset(32'h0000_0B00);
      rd(2'd2, d); chk("R4 no equal after event", d, 16'h0101);

      // R12 write-one-to-clear
      wr(2'd2, 16'h0000);
      rd(2'd2, d); chk("R12 zero write keeps", d, 16'h0101);
      wr(2'd2, 16'h0100);
      rd(2'd2, d); chk("R12 event cleared", d, 16'h0001);
      @(negedge clk);
      rd(2'd2, d); chk("R3 re-arm at level", d, 16'h0101);
      rd(2'd1, d); chk("R3 recapture", d, 16'h0B00);

      // R10 timer-interrupt mode
      wr(2'd0, 16'h0103);
      chk("R10 pin_out=pol", pin_out, 1);
      wr(2'd2, 16'h0180);
      rd(2'd2, d); chk("R10 status clean", d, 16'h0001);
      wr(2'd1, 16'h0C00);
      tset(32'h0000_0C00);
      rd(2'd2, d); chk("R10 equal only", d, 16'h0081);
      chk("R10 irq despite mask", irq, 1);
      wr(2'd2, 16'h0080);
      chk("R12 irq after clear", irq, 0);

      // R5 entry with pin already at level
      tset(32'h0000_0D00);
      wr(2'd0, 16'h1001);
      @(negedge clk);
      rd(2'd2, d); chk("R5 event on entry", d, 16'h0101);
      rd(2'd1, d); chk("R5 entry time", d, 16'h0D00);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule